// File: doc/BRIEF.md
# Standby Wake-Up Request Controller

This block decides which of sixteen external interrupt request lines may pull the chip out of software standby. A per-line enable mask sits behind a small register port. While software standby is active, the block watches only the request lines whose mask bit is set. The first enabled request starts an oscillator-settling countdown. When the countdown expires, a one-cycle wake pulse is issued and the block drops back to its idle state.

Requests are active-high levels. Each one passes through a two-flop synchronizer before it is compared with the mask. The settling interval is a cycle count held in a second register, so firmware can set it to suit the oscillator in use. Asserting the hardware-standby input puts the mask back to its default and abandons any software standby in progress.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After reset the mask (register address 0) reads 0x0007, meaning lines 0, 1 and 2 are enabled. The settle register (address 1) reads SETTLE_RST, and wake is low.
- R2: A write to address 0 stores all N_IRQ mask bits, where bit n enables line n. A write to address 1 stores the low CNT_W bits as the settle count. Both registers read back on rdata in the same cycle, and the settle value is zero-extended.
- R3: While hw_stby is high, the mask is loaded with 0x0007 on the next edge and the block returns to idle. A software standby that was pending produces no wake.
- R4: In software standby, a request on a line whose mask bit is 0 causes no wake.
- R5: In software standby, an enabled request that rises between edges makes wake high after edge K+3, counted from that change, where K is the settle count. Two edges go to synchronization, one to detection, and K to the countdown.
- R6: Wake is high for exactly one cycle. The block is then idle, and later requests cause no wake until stby_enter is pulsed again.
- R7: Requests that arrive while the countdown runs neither restart nor shorten it.
- R8: Outside software standby, requests produce no wake whatever the mask holds.
- R9: A mask write made in standby acts on sampling from the next cycle. If an enabled line is already high, wake follows K+2 edges after the write is presented.
- R10: A settle count of 0 gives wake right after the detection edge, which is edge 3 from the request change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby: restores the default mask and forces idle |
| stby_enter | input | 1 | One-cycle strobe that enters software standby |
| irq_req | input | N_IRQ | Active-high interrupt request levels |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | Register select: 0 is the mask, 1 is the settle count |
| reg_wdata | input | N_IRQ | Register write data |
| reg_rdata | output | N_IRQ | Register read data for reg_addr |
| wake | output | 1 | One-cycle standby exit pulse |

## Verification
The bench builds the block with sixteen request lines, an 8-bit settle counter and a default settle count of 4. This keeps every wake latency short enough to measure edge by edge. Settle counts of 0, 4 and 6 are programmed to cover the zero case, the default and a countdown long enough for a second request to land in the middle of it. With the 8-bit counter, the zero-extended readback of address 1 is also exercised.

// File: rtl/stby_wake_pkg.sv
package stby_wake_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STBY   = 2'd1,
    PH_SETTLE = 2'd2
  } phase_t;

  // True when any request line is both active and enabled (up to 32 lines).
  function automatic logic any_enabled(input logic [31:0] req,
                                       input logic [31:0] en);
    return |(req & en);
  endfunction

  // True when the countdown has expired.
  function automatic logic count_done(input logic [31:0] cnt);
    return cnt == 32'd0;
  endfunction

endpackage

// File: rtl/wake_irq_sync.sv
module wake_irq_sync #(
  parameter int N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  output logic [N_IRQ-1:0] irq_s
);

  // One two-stage synchronizer per request line.
  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic st1_q, st2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1_q <= 1'b0;
        st2_q <= 1'b0;
      end else begin
        st1_q <= irq_in[g];
        st2_q <= st1_q;
      end
    end
    assign irq_s[g] = st2_q;
  end

endmodule

// File: rtl/wake_regs.sv
module wake_regs #(
  parameter int               N_IRQ      = 16,
  parameter int               CNT_W      = 16,
  parameter logic [N_IRQ-1:0] MASK_RST   = 'h7,
  parameter logic [CNT_W-1:0] SETTLE_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             we,
  input  logic             addr,
  input  logic [N_IRQ-1:0] wdata,
  output logic [N_IRQ-1:0] rdata,
  output logic [N_IRQ-1:0] mask_q,
  output logic [CNT_W-1:0] settle_q
);

  localparam logic ADDR_MASK   = 1'b0;
  localparam logic ADDR_SETTLE = 1'b1;

  // The mask register: hardware standby takes priority over a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        mask_q <= MASK_RST;
    else if (hw_stby)                  mask_q <= MASK_RST;
    else if (we && addr == ADDR_MASK)  mask_q <= wdata;
  end

  // The settle count register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          settle_q <= SETTLE_RST;
    else if (we && addr == ADDR_SETTLE)  settle_q <= wdata[CNT_W-1:0];
  end

  // Read data for the selected register; the settle value is zero-extended.
  always_comb begin
    if (addr == ADDR_SETTLE) rdata = N_IRQ'(settle_q);
    else                     rdata = mask_q;
  end

endmodule

// File: rtl/wake_settle_fsm.sv
module wake_settle_fsm
  import stby_wake_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             stby_enter,
  input  logic             hit,
  input  logic [CNT_W-1:0] settle_load,
  output phase_t           phase_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wake
);

  logic cnt_zero;
  assign cnt_zero = count_done(32'(cnt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (hw_stby) begin
      // Hardware standby abandons any software standby in progress.
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE:
          if (stby_enter) phase_q <= PH_STBY;
        PH_STBY:
          if (hit) begin
            // First enabled request: load the settling countdown.
            phase_q <= PH_SETTLE;
            cnt_q   <= settle_load;
          end
        PH_SETTLE:
          // New requests are ignored here, so the countdown is not restarted.
          if (cnt_zero) phase_q <= PH_IDLE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        default:
          phase_q <= PH_IDLE;
      endcase
    end
  end

  assign wake = (phase_q == PH_SETTLE) && cnt_zero;

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_wake_pkg::*;
#(
  parameter int               N_IRQ      = 16,
  parameter int               CNT_W      = 16,
  parameter logic [N_IRQ-1:0] MASK_RST   = 'h7,
  parameter logic [CNT_W-1:0] SETTLE_RST = CNT_W'(1024)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_stby,
  input  logic             stby_enter,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [N_IRQ-1:0] reg_wdata,
  output logic [N_IRQ-1:0] reg_rdata,
  output logic             wake
);

  // Internal events, brought out as named wires for the checker.
  logic [N_IRQ-1:0] irq_s;
  logic [N_IRQ-1:0] mask_q;
  logic [CNT_W-1:0] settle_q;
  logic [CNT_W-1:0] cnt_q;
  phase_t           phase_q;
  logic             in_stby;
  logic             in_settle;
  logic             hit;

  wake_irq_sync #(.N_IRQ(N_IRQ)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_in (irq_req),
    .irq_s  (irq_s)
  );

  wake_regs #(
    .N_IRQ      (N_IRQ),
    .CNT_W      (CNT_W),
    .MASK_RST   (MASK_RST),
    .SETTLE_RST (SETTLE_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_stby  (hw_stby),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .mask_q   (mask_q),
    .settle_q (settle_q)
  );

  assign in_stby   = (phase_q == PH_STBY);
  assign in_settle = (phase_q == PH_SETTLE);
  // Lines are sampled only in software standby, through the live mask.
  assign hit       = in_stby && any_enabled(32'(irq_s), 32'(mask_q));

  wake_settle_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_stby     (hw_stby),
    .stby_enter  (stby_enter),
    .hit         (hit),
    .settle_load (settle_q),
    .phase_q     (phase_q),
    .cnt_q       (cnt_q),
    .wake        (wake)
  );

endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk #(
  parameter int               N_IRQ    = 16,
  parameter int               CNT_W    = 16,
  parameter logic [N_IRQ-1:0] MASK_RST = 'h7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hw_stby,
  input logic             wake,
  input logic             in_stby,
  input logic             in_settle,
  input logic             hit,
  input logic [CNT_W-1:0] cnt_q,
  input logic [N_IRQ-1:0] mask_q
);

  // R3: hardware standby reloads the default mask
  p_hw_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (mask_q == MASK_RST));

  // R3: hardware standby forces idle
  p_hw_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (!in_stby && !in_settle));

  // R6: wake lasts a single cycle
  p_wake_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R6: idle follows wake
  p_wake_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !hw_stby) |=> (!in_stby && !in_settle));

  // R8: no wake outside standby
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_stby && !in_settle) |-> !wake);

  // R5: an enabled request starts the countdown
  p_hit_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !hw_stby) |=> in_settle);

  // R7: the countdown steps down by one and is never reloaded
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_settle && cnt_q != '0 && !hw_stby) |=>
      (in_settle && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

bind stby_wake_ctrl stby_wake_chk #(
  .N_IRQ    (N_IRQ),
  .CNT_W    (CNT_W),
  .MASK_RST (MASK_RST)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hw_stby   (hw_stby),
  .wake      (wake),
  .in_stby   (in_stby),
  .in_settle (in_settle),
  .hit       (hit),
  .cnt_q     (cnt_q),
  .mask_q    (mask_q)
);

// File: tb/test_stby_wake_ctrl.sv
`timescale 1ns/1ps
module test_stby_wake_ctrl;

  localparam int N = 16;
  localparam int CW = 8;
  localparam logic [N-1:0] MRST = 16'h0007;
  localparam logic [CW-1:0] SRST = 8'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_stby = 1'b0;
  logic stby_enter = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic reg_we = 1'b0;
  logic reg_addr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  stby_wake_ctrl #(
    .N_IRQ(N), .CNT_W(CW), .MASK_RST(MRST), .SETTLE_RST(SRST)
  ) i_stby_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .stby_enter(stby_enter),
    .irq_req(irq_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic enter_stby();
    @(negedge clk);
    stby_enter = 1'b1;
    @(negedge clk);
    stby_enter = 1'b0;
  endtask

  // Drives irq at the current negedge, then counts edges until wake is seen.
  // Optional extra bits are ORed in after edge extra_at.
  task automatic measure(input logic [N-1:0] irq_val, input int extra_at,
                         input logic [N-1:0] extra_bits, input int nmax,
                         output int first, output int pulses);
    first = 0; pulses = 0;
    irq_req = irq_val;
    for (int i = 1; i <= nmax; i++) begin
      @(posedge clk);
      @(negedge clk);
      reg_we = 1'b0;
      if (wake) begin
        if (first == 0) first = i;
        pulses++;
      end
      if (i == extra_at) irq_req = irq_req | extra_bits;
    end
  endtask

  task automatic idle_clear();
    @(negedge clk);
    irq_req = '0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [N-1:0] d;
    rd(1'b0, d); chk(d == MRST, "R1 mask reset", int'(d), int'(MRST));
    rd(1'b1, d); chk(d == N'(SRST), "R1 settle reset", int'(d), int'(SRST));
    chk(wake == 1'b0, "R1 wake low", int'(wake), 0);
  endtask

  task automatic t_reg_rw();
    logic [N-1:0] d;
    wr(1'b0, 16'hA5C3); rd(1'b0, d); chk(d == 16'hA5C3, "R2 mask rw", int'(d), 16'hA5C3);
    wr(1'b0, 16'h5A3C); rd(1'b0, d); chk(d == 16'h5A3C, "R2 mask rw2", int'(d), 16'h5A3C);
    wr(1'b1, 16'hFF09); rd(1'b1, d); chk(d == 16'h0009, "R2 settle zero-ext", int'(d), 9);
    wr(1'b1, 16'h0004); wr(1'b0, MRST);
  endtask

  task automatic t_latency(input int k, input int bitn, input string req);
    int f, p;
    wr(1'b1, N'(k));
    enter_stby();
    measure(N'(1) << bitn, 0, '0, k + 8, f, p);
    chk(f == k + 3, req, f, k + 3);
    chk(p == 1, "R6 single pulse", p, 1);
    idle_clear();
    measure(N'(1) << bitn, 0, '0, k + 8, f, p);
    chk(p == 0, "R6 idle after wake", p, 0);
    idle_clear();
  endtask

  task automatic t_disabled();
    int f, p;
    wr(1'b1, 16'd4); wr(1'b0, MRST);
    enter_stby();
    measure(16'h0200, 0, '0, 16, f, p);
    chk(p == 0, "R4 disabled line ignored", p, 0);
    measure(16'h0202, 0, '0, 12, f, p);
    chk(f == 7, "R4 enabled line still wakes", f, 7);
    idle_clear();
  endtask

  task automatic t_no_restart();
    int f, p;
    wr(1'b1, 16'd6); wr(1'b0, 16'hFFFF);
    enter_stby();
    measure(16'h0001, 5, 16'h8000, 16, f, p);
    chk(f == 9, "R7 no restart", f, 9);
    chk(p == 1, "R7 one pulse", p, 1);
    idle_clear();
  endtask

  task automatic t_outside();
    int f, p;
    wr(1'b1, 16'd2); wr(1'b0, 16'hFFFF);
    measure(16'hFFFF, 0, '0, 16, f, p);
    chk(p == 0, "R8 no wake outside standby", p, 0);
    idle_clear();
  endtask

  task automatic t_mask_live();
    int f, p;
    wr(1'b1, 16'd4); wr(1'b0, 16'h0000);
    enter_stby();
    measure(16'h0020, 0, '0, 8, f, p);
    chk(p == 0, "R9 masked before write", p, 0);
    reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h0020;
    measure(16'h0020, 0, '0, 12, f, p);
    chk(f == 6, "R9 write acts next cycle", f, 6);
    idle_clear();
  endtask

  task automatic t_hw_stby();
    int f, p;
    logic [N-1:0] d;
    wr(1'b1, 16'd4); wr(1'b0, 16'hABCD);
    enter_stby();
    @(negedge clk); hw_stby = 1'b1;
    @(negedge clk); hw_stby = 1'b0;
    rd(1'b0, d); chk(d == MRST, "R3 mask restored", int'(d), int'(MRST));
    measure(16'h0009, 0, '0, 16, f, p);
    chk(p == 0, "R3 standby abandoned", p, 0);
    idle_clear();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_reg_rw();
    t_latency(4, 0, "R5 latency K=4");
    t_latency(0, 2, "R10 zero settle");
    t_disabled();
    t_no_restart();
    t_outside();
    t_mask_live();
    t_hw_stby();
    finish_run();
  end

endmodule